// File: doc/BRIEF.md
# Sampling Rate Classifier with Hysteresis

The block times a recovered frame-sync strobe against a 24.576 MHz reference clock and sorts the result into one of thirteen standard audio sampling rates, from 8 kHz up to 192 kHz. Each measurement spans eight frame periods. The counts run back to back, so a new result arrives every eight frames. A matched rate is reported as a 4-bit code with a valid flag. A separate high-rate output follows the measured rate through a hysteresis band: it rises above 64 kHz, falls below 54 kHz, and holds its state between the two.

The block also watches how stable the incoming sync is. It raises an unlock flag when two successive measurements disagree by more than the tolerance, or when the strobe stops for too long. The flag drops again only after the strobe has proven steady. Downstream logic uses the code to configure clocking, the high-rate output to pick a double- or quad-rate path, and the unlock flag to mute or hold until the source settles.

Top module: `rate_classifier`

## Requirements
- R1: After reset the rate code is 15 (unknown), rate-valid is 0, the high-rate output is 0 and unlock is 1.
- R2: A measurement m is the number of reference cycles from one strobe to the 8th strobe after it, and the completing strobe starts the next measurement. Codes 0 to 12 name 8, 11.025, 16, 22.05, 24, 32, 44.1, 48, 64, 88.2, 96, 176.4 and 192 kHz in that order, each with nominal count N = floor(8*24576000/f). Code k matches when |m-N|*100 <= 3*N. All outputs take their new values on the clock edge that samples the completing strobe.
- R3: A measurement that matches no rate clears rate-valid and leaves the rate code unchanged.
- R4: A measurement that matches a rate sets rate-valid to 1 and loads that rate's code.
- R5: The high-rate output is set by a measurement with m < 3072 (above 64 kHz) and cleared by one with m > 3640 (below 54 kHz). Any measurement in between leaves it unchanged, and this includes exactly 64 kHz.
- R6: A measurement with |m - previous m|*100 > 3 * previous m sets unlock.
- R7: Unlock clears on the second of two consecutive consistent measurements. The first measurement after reset or after a timeout has no predecessor, so it neither sets nor clears unlock.
- R8: If 65536 reference cycles pass with no strobe, unlock is set, rate-valid is cleared, any partial measurement is dropped and the next strobe begins a fresh one. The rate code and the high-rate output are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 24.576 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_strobe_i | input | 1 | One-cycle frame-sync pulse, synchronous to clk_ref |
| rate_code_o | output | 4 | Classified rate code, 0 to 12, or 15 for unknown |
| rate_valid_o | output | 1 | Last measurement matched a known rate |
| high_rate_o | output | 1 | High-rate indicator with 54/64 kHz hysteresis |
| unlock_o | output | 1 | Sync interval inconsistent or missing |

## Verification
On every cycle, the assertions check the structural rules of the outputs. The code is always a legal value, a valid flag is never paired with the unknown code, and the code and high-rate output change only on a frame strobe. Unlock rises only on a strobe or after a full idle timeout, and it falls only on a strobe. Whether a given period lands in the right window is a different matter. So are the exact hysteresis thresholds, including the hold at exactly 64 kHz, the two-step recovery from unlock, and the behaviour after a timeout. The bench can show these only by driving strobe trains at chosen and randomised periods and comparing each result with its own model.

// File: rtl/rate_cls_pkg.sv
package rate_cls_pkg;

    localparam int NUM_RATES = 13;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_UNKNOWN = 4'hF;

    // Standard sampling rates in ascending order; index is the rate code.
    function automatic longint rate_hz(input int idx);
        case (idx)
            0:       return 64'd8000;
            1:       return 64'd11025;
            2:       return 64'd16000;
            3:       return 64'd22050;
            4:       return 64'd24000;
            5:       return 64'd32000;
            6:       return 64'd44100;
            7:       return 64'd48000;
            8:       return 64'd64000;
            9:       return 64'd88200;
            10:      return 64'd96000;
            11:      return 64'd176400;
            12:      return 64'd192000;
            default: return 64'd1;
        endcase
    endfunction

    // Reference cycles expected across a multi-frame measurement.
    function automatic longint nominal_count(input int idx, input longint frames,
                                             input longint ref_hz);
        return (frames * ref_hz) / rate_hz(idx);
    endfunction

endpackage

// File: rtl/rate_period_meter.sv
module rate_period_meter #(
    parameter int FRAMES      = 8,
    parameter int TIMEOUT_CYC = 65536,
    parameter int CNT_W       = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    output logic             done_o,
    output logic [CNT_W-1:0] meas_o,
    output logic             timeout_o
);
    localparam int FR_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam int GAP_W = $clog2(TIMEOUT_CYC);
    localparam logic [FR_W-1:0]  LAST_FR  = FR_W'(FRAMES - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic             armed;
        logic [FR_W-1:0]  frames;
        logic [CNT_W-1:0] cnt;
        logic [GAP_W-1:0] gap;
    } meter_t;

    meter_t st_d, st_q;
    logic   done_d;
    logic   tmo_d;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
        st_d    = st_q;
        done_d  = 1'b0;
        tmo_d   = 1'b0;
        if (strobe_i) begin
            st_d.gap = '0;
            if (!st_q.armed) begin
                st_d.armed  = 1'b1;
                st_d.frames = '0;
                st_d.cnt    = '0;
            end else if (st_q.frames == LAST_FR) begin
                done_d      = 1'b1;
                st_d.frames = '0;
                st_d.cnt    = '0;
            end else begin
                st_d.frames = st_q.frames + 1'b1;
                st_d.cnt    = cnt_inc;
            end
        end else if (st_q.gap == GAP_LAST) begin
            tmo_d       = 1'b1;
            st_d.gap    = '0;
            st_d.armed  = 1'b0;
            st_d.frames = '0;
            st_d.cnt    = '0;
        end else begin
            st_d.gap = st_q.gap + 1'b1;
            if (st_q.armed) st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o    = done_d;
    assign meas_o    = cnt_inc;
    assign timeout_o = tmo_d;
endmodule

// File: rtl/rate_window_match.sv
module rate_window_match #(
    parameter int FRAMES  = 8,
    parameter int REF_HZ  = 24576000,
    parameter int TOL_PCT = 3,
    parameter int CNT_W   = 20
) (
    input  logic [CNT_W-1:0]                   meas_i,
    output logic                               hit_o,
    output logic [rate_cls_pkg::CODE_W-1:0]    code_o
);
    import rate_cls_pkg::*;

    logic [NUM_RATES-1:0] hit_vec;

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_win
        localparam longint NOM  = nominal_count(i, FRAMES, REF_HZ);
        localparam longint TOLC = (NOM * TOL_PCT) / 100;
        localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOLC);
        localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOLC);
        assign hit_vec[i] = (meas_i >= LO) && (meas_i <= HI);
    end

    always_comb begin
        code_o = CODE_UNKNOWN;
        for (int k = NUM_RATES - 1; k >= 0; k--) begin
            if (hit_vec[k]) code_o = CODE_W'(k);
        end
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/rate_classifier.sv
module rate_classifier #(
    parameter int REF_HZ      = 24576000,
    parameter int FRAMES      = 8,
    parameter int TIMEOUT_CYC = 65536,
    parameter int TOL_PCT     = 3,
    parameter int HI_SET_HZ   = 64000,
    parameter int HI_CLR_HZ   = 54000
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       frame_strobe_i,
    output logic [3:0] rate_code_o,
    output logic       rate_valid_o,
    output logic       high_rate_o,
    output logic       unlock_o
);
    import rate_cls_pkg::*;

    localparam int CNT_W = $clog2(FRAMES * TIMEOUT_CYC) + 1;
    localparam int WID_W = CNT_W + 8;
    localparam logic [CNT_W-1:0] HI_SET_CNT =
        CNT_W'((longint'(FRAMES) * REF_HZ) / HI_SET_HZ);
    localparam logic [CNT_W-1:0] HI_CLR_CNT =
        CNT_W'((longint'(FRAMES) * REF_HZ) / HI_CLR_HZ);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              valid;
        logic              hi;
        logic              unlock;
        logic [CNT_W-1:0]  prev;
        logic              have_prev;
        logic              one_ok;
    } cls_t;

    logic              done;
    logic              timeout;
    logic [CNT_W-1:0]  meas;
    logic              hit;
    logic [CODE_W-1:0] hit_code;

    rate_period_meter #(
        .FRAMES(FRAMES), .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)
    ) u_meter (
        .clk(clk_ref), .rst_n(rst_n), .strobe_i(frame_strobe_i),
        .done_o(done), .meas_o(meas), .timeout_o(timeout)
    );

    rate_window_match #(
        .FRAMES(FRAMES), .REF_HZ(REF_HZ), .TOL_PCT(TOL_PCT), .CNT_W(CNT_W)
    ) u_match (
        .meas_i(meas), .hit_o(hit), .code_o(hit_code)
    );

    cls_t st_d, st_q;
    logic [CNT_W-1:0] diff;
    logic [WID_W-1:0] diff_scaled;
    logic [WID_W-1:0] tol_scaled;
    logic             jump;

    always_comb begin
        diff        = (meas >= st_q.prev) ? meas - st_q.prev : st_q.prev - meas;
        diff_scaled = WID_W'(diff) * WID_W'(100);
        tol_scaled  = WID_W'(st_q.prev) * WID_W'(TOL_PCT);
        jump        = diff_scaled > tol_scaled;

        st_d = st_q;
        if (timeout) begin
            st_d.valid     = 1'b0;
            st_d.unlock    = 1'b1;
            st_d.have_prev = 1'b0;
            st_d.one_ok    = 1'b0;
        end else if (done) begin
            if (hit) begin
                st_d.code  = hit_code;
                st_d.valid = 1'b1;
            end else begin
                st_d.valid = 1'b0;
            end
            if (meas < HI_SET_CNT)      st_d.hi = 1'b1;
            else if (meas > HI_CLR_CNT) st_d.hi = 1'b0;
            if (!st_q.have_prev) begin
                st_d.one_ok = 1'b0;
            end else if (jump) begin
                st_d.unlock = 1'b1;
                st_d.one_ok = 1'b0;
            end else if (st_q.one_ok) begin
                st_d.unlock = 1'b0;
            end else begin
                st_d.one_ok = 1'b1;
            end
            st_d.prev      = meas;
            st_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.code      <= CODE_UNKNOWN;
            st_q.unlock    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_code_o  = st_q.code;
    assign rate_valid_o = st_q.valid;
    assign high_rate_o  = st_q.hi;
    assign unlock_o     = st_q.unlock;
endmodule

// File: rtl/rate_classifier_chk.sv
module rate_classifier_chk #(
    parameter int TIMEOUT_CYC = 65536
) (
    input logic       clk_ref,
    input logic       rst_n,
    input logic       frame_strobe_i,
    input logic [3:0] rate_code_o,
    input logic       rate_valid_o,
    input logic       high_rate_o,
    input logic       unlock_o
);
    localparam int IW = $clog2(TIMEOUT_CYC) + 1;
    localparam logic [IW-1:0] IDLE_LIM = IW'(TIMEOUT_CYC - 1);

    logic [IW-1:0] idle_q;
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)                 idle_q <= '0;
        else if (frame_strobe_i)    idle_q <= '0;
        else if (idle_q < IDLE_LIM) idle_q <= idle_q + 1'b1;
    end

    a_r2_code_legal: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rate_code_o <= 4'd12) || (rate_code_o == 4'hF));

    a_r4_valid_has_code: assert property (@(posedge clk_ref) disable iff (!rst_n)
        rate_valid_o |-> (rate_code_o != 4'hF));

    a_r3_code_moves_on_strobe: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$stable(rate_code_o) |-> $past(frame_strobe_i));

    a_r5_hi_moves_on_strobe: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$stable(high_rate_o) |-> $past(frame_strobe_i));

    a_r6_unlock_rise_cause: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(unlock_o) |-> ($past(frame_strobe_i) || ($past(idle_q) >= IDLE_LIM)));

    a_r7_unlock_fall_on_strobe: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(unlock_o) |-> $past(frame_strobe_i));

    a_r8_valid_fall_cause: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(rate_valid_o) |-> ($past(frame_strobe_i) || ($past(idle_q) >= IDLE_LIM)));
endmodule

bind rate_classifier rate_classifier_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk_ref(clk_ref), .rst_n(rst_n), .frame_strobe_i(frame_strobe_i),
    .rate_code_o(rate_code_o), .rate_valid_o(rate_valid_o),
    .high_rate_o(high_rate_o), .unlock_o(unlock_o)
);

// File: tb/rate_classifier_bench.sv
module rate_classifier_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [3:0] code;
    logic       valid, hi, unlock;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rate_classifier u_rate_classifier (
        .clk_ref(clk), .rst_n(rst_n), .frame_strobe_i(strobe),
        .rate_code_o(code), .rate_valid_o(valid),
        .high_rate_o(hi), .unlock_o(unlock)
    );

    // Bench model state
    int  m_code = 15;
    bit  m_valid = 0, m_hi = 0, m_unlock = 1, m_havep = 0, m_run = 0;
    int  m_prev = 0;

    function automatic int rate_of(input int i);
        int tbl[13] = '{8000, 11025, 16000, 22050, 24000, 32000, 44100,
                        48000, 64000, 88200, 96000, 176400, 192000};
        return tbl[i];
    endfunction

    function automatic int nom_of(input int i);
        return 196608000 / rate_of(i);
    endfunction

    function automatic int classify(input int m);
        for (int i = 0; i < 13; i++) begin
            int n = nom_of(i);
            int d = (m > n) ? m - n : n - m;
            if (d * 100 <= 3 * n) return i;
        end
        return 15;
    endfunction

    task automatic model_block(input int m);
        int c = classify(m);
        if (c != 15) begin m_code = c; m_valid = 1; end
        else m_valid = 0;
        if (m < 3072) m_hi = 1;
        else if (m > 3640) m_hi = 0;
        if (m_havep) begin
            int d = (m > m_prev) ? m - m_prev : m_prev - m;
            if (d * 100 > 3 * m_prev) begin m_unlock = 1; m_run = 0; end
            else if (m_run) m_unlock = 0;
            else m_run = 1;
        end else m_run = 0;
        m_prev = m;
        m_havep = 1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string what);
        chk({what, " R2 code"}, code, m_code);
        chk(m_valid ? {what, " R4 valid"} : {what, " R3 valid"}, valid, m_valid);
        chk({what, " R5 high-rate"}, hi, m_hi);
        chk({what, " R6/R7 unlock"}, unlock, m_unlock);
    endtask

    task automatic pulse(input int p);
        repeat (p - 1) @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    // Eight frames of period p, then compare against the model.
    task automatic block(input int p, input string what);
        repeat (8) pulse(p);
        model_block(8 * p);
        check_all(what);
    endtask

    initial begin : watchdog
        repeat (198000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 code", code, 15);
        chk("R1 valid", valid, 0);
        chk("R1 high-rate", hi, 0);
        chk("R1 unlock", unlock, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        pulse(512);                         // arm first measurement
        block(512, "48k first");            // no predecessor: unlock held
        block(512, "48k second");           // one consistent
        block(512, "48k third");            // R7: unlock clears
        chk("R7 unlock cleared", unlock, 0);
        block(256, "96k jump");             // R6 unlock, R5 set
        chk("R6 unlock on jump", unlock, 1);
        block(400, "band unmatched");       // R3 hold code, R5 hold high
        chk("R3 code held", code, 10);
        block(384, "exact 64k");            // R5 holds at 64 kHz
        chk("R5 held at 64k", hi, 1);
        block(512, "48k back");             // R5 clear
        block(400, "band low");             // R5 hold low
        chk("R5 held low", hi, 0);
        block(128, "192k a");
        block(128, "192k b");
        block(128, "192k c");
        chk("R7 relock 192k", unlock, 0);
        block(557, "44.1k");
        chk("R4 code 44.1k", code, 6);

        for (int it = 0; it < 4; it++) begin
            int idx = $urandom_range(12, 7);
            int p = nom_of(idx) / 8 + $urandom_range(4, 0) - 2;
            if ($urandom_range(3, 0) == 0) p = p + p * 6 / 100;
            block(p, "random a");
            block(p, "random b");
        end

        // R8 timeout
        repeat (66000) @(negedge clk);
        m_valid = 0; m_unlock = 1; m_havep = 0; m_run = 0;
        chk("R8 unlock", unlock, 1);
        chk("R8 valid", valid, 0);
        chk("R8 code held", code, m_code);
        chk("R8 high held", hi, m_hi);

        pulse(3072);                        // fresh start after timeout
        block(3072, "8k after timeout");
        chk("R8 no predecessor", unlock, 1);
        chk("R4 code 8k", code, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule